// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer with a small byte-addressed register bus. It counts down on a slow tick strobe from a programmable initial value. Software keeps the system alive by writing to the count register, which reloads the counter. A halt bit in the control register stops counting altogether.

Expiry happens in two stages. When the counter runs out the first time, it raises a sticky timeout flag and starts again from the initial value. If it runs out a second time while that flag is still set, it raises a second-timeout flag and issues a one-cycle system reset request. Software can block that request with a no-reboot gate bit. The status flags are cleared by writing 1 to them.

The register bus is a single-cycle write strobe with a combinational read. Every write is accepted in the cycle it is presented, so there is no back-pressure. The tick is a one-cycle enable, typically derived from a 0.6 s time base, so a timeout of N seconds needs about N*10/6 ticks.

Top module: `wdt_twostage`

## Requirements
- R1: After reset the halt bit (control register 0x08, bit 11) reads 1, the no-reboot bit (register 0x0A, bit 0) reads 1, the initial value and the count both read INIT_DEF, every status bit reads 0 and rst_req is 0.
- R2: On each tick with halt at 0, no reload and a count above 0, the count read at offset 0x00 (bits CNT_W-1:0) drops by exactly one at that clock edge.
- R3: A write of any data to offset 0x00 sets the count to the initial value at that edge. It takes priority over a tick in the same cycle, and that tick causes no expiry.
- R4: Reading offset 0x00 returns the current count, with the bits above CNT_W reading 0. Unmapped offsets read 0.
- R5: A write to offset 0x02 stores bits DATA_W-1:CNT_W as read-back scratch bits. It loads bits CNT_W-1:0 as the new initial value only if they are 4 or more; values 0 to 3 leave the previous initial value in place.
- R6: While the halt bit is 1, ticks leave the count unchanged.
- R7: A tick that arrives with the count at 0 and halt at 0 is an expiry. The first expiry sets the timeout flag (offset 0x04, bit 3), reloads the count to the initial value and requests no reset.
- R8: An expiry while the timeout flag is already set sets the second-timeout flag (offset 0x06, bit 1). It also drives rst_req high for exactly one cycle, starting in the cycle after that tick's edge, provided the no-reboot bit is 0.
- R9: While the no-reboot bit is 1, a second expiry produces no rst_req but still sets the second-timeout flag. The no-reboot bit reads back as written.
- R10: Status bits clear only when 1 is written to them; writing 0 leaves them unchanged. A set and a clear in the same cycle leave the bit set.
- R11: A pulse on boot_fail sets the boot status flag (offset 0x06, bit 2), which clears on a write of 1 to that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count enable strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| boot_fail | input | 1 | Sets the boot status flag |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with a 6-bit count field and an initial value of 5. This gives the narrow field layout, with ten scratch bits in the initial-value register. It also means a full expiry takes only six ticks, so first and second expiries, blocked resets and reload races all occur many times within a short run. The small field also makes random writes to the initial-value register land on the illegal values 0 to 3 often, which exercises the rule that such writes are ignored.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  // register byte offsets; offset = 2 * register index
  localparam int NREG     = 6;
  localparam int REG_CUR  = 0;
  localparam int REG_INIT = 1;
  localparam int REG_STS1 = 2;
  localparam int REG_STS2 = 3;
  localparam int REG_CTRL = 4;
  localparam int REG_NORB = 5;

  // bit positions that software decodes
  localparam int BIT_TO   = 3;
  localparam int BIT_SEC  = 1;
  localparam int BIT_BOOT = 2;
  localparam int BIT_HALT = 11;
  localparam int BIT_NORB = 0;

  localparam int MIN_INIT = 4;

  typedef struct packed {
    logic to;
    logic sec;
    logic boot;
  } wdt_sts_t;
endpackage

// File: rtl/wdt2_decode.sv
module wdt2_decode
  import wdt2_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NREG-1:0]   wr_sel,
  output logic [NREG-1:0]   rd_sel
);
  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign rd_sel[i] = (bus_addr == ADDR_W'(2 * i));
    assign wr_sel[i] = bus_wr && rd_sel[i];
  end
endmodule

// File: rtl/wdt2_regs.sv
module wdt2_regs
  import wdt2_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 10,
  parameter int INIT_DEF = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG-1:0]   wr_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  input  logic              boot_fail,
  output logic [CNT_W-1:0]  init_val,
  output logic [DATA_W-1:0] init_word,
  output logic              halt,
  output logic              norb,
  output wdt_sts_t          sts
);
  localparam int SPARE_W = DATA_W - CNT_W;

  logic [CNT_W-1:0] init_q;
  wdt_sts_t         sts_q;
  logic             halt_q, norb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= CNT_W'(INIT_DEF);
    end else if (wr_sel[REG_INIT] && (wdata[CNT_W-1:0] >= CNT_W'(MIN_INIT))) begin
      init_q <= wdata[CNT_W-1:0];
    end
  end

  if (SPARE_W > 0) begin : g_spare
    logic [SPARE_W-1:0] spare_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                spare_q <= '0;
      else if (wr_sel[REG_INIT]) spare_q <= wdata[DATA_W-1:CNT_W];
    end
    assign init_word = {spare_q, init_q};
  end else begin : g_nospare
    assign init_word = init_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
      norb_q <= 1'b1;
    end else begin
      if (wr_sel[REG_CTRL]) halt_q <= wdata[BIT_HALT];
      if (wr_sel[REG_NORB]) norb_q <= wdata[BIT_NORB];
    end
  end

  // status: a set event wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else begin
      if (expire)                                   sts_q.to <= 1'b1;
      else if (wr_sel[REG_STS1] && wdata[BIT_TO])   sts_q.to <= 1'b0;
      if (expire && sts_q.to)                       sts_q.sec <= 1'b1;
      else if (wr_sel[REG_STS2] && wdata[BIT_SEC])  sts_q.sec <= 1'b0;
      if (boot_fail)                                sts_q.boot <= 1'b1;
      else if (wr_sel[REG_STS2] && wdata[BIT_BOOT]) sts_q.boot <= 1'b0;
    end
  end

  assign init_val = init_q;
  assign halt     = halt_q;
  assign norb     = norb_q;
  assign sts      = sts_q;
endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter #(
  parameter int CNT_W    = 10,
  parameter int INIT_DEF = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             halt,
  input  logic             reload,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step   = tick && !halt && !reload;
  assign expire = step && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(INIT_DEF);
    else if (reload) cnt_q <= init_val;
    else if (expire) cnt_q <= init_val;
    else if (step)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
  import wdt2_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 10,
  parameter int INIT_DEF = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              boot_fail,
  output logic              rst_req
);
  logic [NREG-1:0]   wr_sel, rd_sel;
  logic [CNT_W-1:0]  init_val, cnt;
  logic [DATA_W-1:0] init_word;
  logic              halt, norb, expire, rst_q;
  wdt_sts_t          sts;

  wdt2_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  wdt2_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .INIT_DEF(INIT_DEF)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(bus_wdata),
    .expire(expire), .boot_fail(boot_fail), .init_val(init_val),
    .init_word(init_word), .halt(halt), .norb(norb), .sts(sts)
  );

  wdt2_counter #(.CNT_W(CNT_W), .INIT_DEF(INIT_DEF)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt),
    .reload(wr_sel[REG_CUR]), .init_val(init_val), .cnt(cnt), .expire(expire)
  );

  // reset request: second expiry, gate open
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= expire && sts.to && !norb;
  end
  assign rst_req = rst_q;

  always_comb begin
    bus_rdata = '0;
    if (rd_sel[REG_CUR])  bus_rdata[CNT_W-1:0] = cnt;
    if (rd_sel[REG_INIT]) bus_rdata = init_word;
    if (rd_sel[REG_STS1]) bus_rdata[BIT_TO] = sts.to;
    if (rd_sel[REG_STS2]) begin
      bus_rdata[BIT_SEC]  = sts.sec;
      bus_rdata[BIT_BOOT] = sts.boot;
    end
    if (rd_sel[REG_CTRL]) bus_rdata[BIT_HALT] = halt;
    if (rd_sel[REG_NORB]) bus_rdata[BIT_NORB] = norb;
  end
endmodule

// File: rtl/wdt_twostage_chk.sv
module wdt_twostage_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             reload,
  input logic             halt,
  input logic             norb,
  input logic             to_flag,
  input logic             expire,
  input logic             rst_req,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] init_val
);
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !halt && !reload && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  a_r3_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == $past(init_val)));

  a_r5_init_legal: assert property (@(posedge clk) disable iff (!rst_n)
    init_val >= CNT_W'(4));

  a_r6_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload) |=> $stable(cnt));

  a_r7_expire_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == $past(init_val)));

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r9_gate_and_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(expire) && $past(to_flag) && !$past(norb)));
endmodule

bind wdt_twostage wdt_twostage_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .reload(wr_sel[0]), .halt(halt),
  .norb(norb), .to_flag(sts.to), .expire(expire), .rst_req(rst_req),
  .cnt(cnt), .init_val(init_val)
);

// File: tb/wdt_twostage_bench.sv
module wdt_twostage_bench;
  localparam int CW = 6;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int ID = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, tick, bus_wr, boot_fail, rst_req;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  wdt_twostage #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .INIT_DEF(ID)) u_wdt_twostage (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .boot_fail(boot_fail), .rst_req(rst_req)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [CW-1:0]    m_cnt, m_init;
  logic [DW-CW-1:0] m_spare;
  logic m_halt, m_nr, m_to, m_sec, m_boot, m_rst;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_rd(int a);
    logic [DW-1:0] r = '0;
    case (a)
      0:  r[CW-1:0] = m_cnt;
      2:  r = {m_spare, m_init};
      4:  r[3] = m_to;
      6:  begin r[1] = m_sec; r[2] = m_boot; end
      8:  r[11] = m_halt;
      10: r[0] = m_nr;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic model_edge(logic t, logic w, int a, logic [DW-1:0] d, logic bf);
    logic [CW-1:0] oc = m_cnt, oi = m_init;
    logic oto = m_to, onr = m_nr, oh = m_halt, ex = 1'b0;
    if (w && a == 0) m_cnt = oi;
    else if (t && !oh) begin
      if (oc == 0) begin m_cnt = oi; ex = 1'b1; end
      else m_cnt = oc - 1'b1;
    end
    m_rst = ex && oto && !onr;
    if (w && a == 2) begin
      m_spare = d[DW-1:CW];
      if (d[CW-1:0] >= 4) m_init = d[CW-1:0];
    end
    if (w && a == 8)  m_halt = d[11];
    if (w && a == 10) m_nr = d[0];
    if (ex) m_to = 1'b1; else if (w && a == 4 && d[3]) m_to = 1'b0;
    if (ex && oto) m_sec = 1'b1; else if (w && a == 6 && d[1]) m_sec = 1'b0;
    if (bf) m_boot = 1'b1; else if (w && a == 6 && d[2]) m_boot = 1'b0;
  endtask

  task automatic step(logic t, logic w, int a, logic [DW-1:0] d, logic bf);
    tick = t; bus_wr = w; bus_addr = AW'(a); bus_wdata = d; boot_fail = bf;
    @(posedge clk);
    model_edge(t, w, a, d, bf);
    @(negedge clk);
    tick = 0; bus_wr = 0; boot_fail = 0;
    chk("R8", {15'b0, rst_req}, {15'b0, m_rst}, "rst_req");
  endtask

  task automatic rd(string req, int a);
    bus_addr = AW'(a);
    #1;
    chk(req, bus_rdata, exp_rd(a), $sformatf("read@%0d", a));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, '0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 0; tick = 0; bus_wr = 0; boot_fail = 0; bus_addr = '0; bus_wdata = '0;
    m_cnt = ID; m_init = ID; m_spare = '0; m_halt = 1; m_nr = 1;
    m_to = 0; m_sec = 0; m_boot = 0; m_rst = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    for (int a = 0; a <= 10; a += 2) rd("R1", a);
    chk("R1", {15'b0, rst_req}, '0, "rst_req after reset");

    // R5 illegal and legal initial values, scratch bits
    step(0, 1, 2, 16'hA5C3, 0); rd("R5", 2);
    chk("R5", {10'b0, bus_rdata[CW-1:0]}, 16'd5, "init kept on value 3");
    step(0, 1, 2, 16'h0004, 0); rd("R5", 2);
    step(0, 1, 2, 16'h0040, 0); rd("R5", 2);

    // R6 halted after reset: ticks do nothing
    ticks(3); rd("R6", 0);
    chk("R6", {10'b0, bus_rdata[CW-1:0]}, 16'd5, "count frozen");

    step(0, 1, 8, 16'h0000, 0);
    step(0, 1, 10, 16'h0000, 0);
    rd("R9", 10);

    // R3 reload, R2 decrement, R4 readback
    step(0, 1, 0, 16'hFFFF, 0); rd("R3", 0);
    ticks(2); rd("R2", 0);
    chk("R4", bus_rdata, 16'd2, "count 4-2");
    step(1, 1, 0, 16'h0000, 0); rd("R3", 0);
    rd("R4", 1);

    // R7 first expiry, R8 second expiry resets
    ticks(5); rd("R7", 4); rd("R7", 0);
    chk("R7", {15'b0, rst_req}, '0, "no reset on first expiry");
    ticks(4); step(1, 0, 0, '0, 0);
    chk("R8", {15'b0, rst_req}, 16'd1, "reset pulse");
    rd("R8", 6);
    step(0, 0, 0, '0, 0);
    chk("R8", {15'b0, rst_req}, '0, "pulse one cycle");

    // R10 write 0 ignored, write 1 clears
    step(0, 1, 4, 16'hFFF7, 0); rd("R10", 4);
    step(0, 1, 4, 16'h0008, 0); rd("R10", 4);
    step(0, 1, 6, 16'h0002, 0); rd("R10", 6);

    // R9 no-reboot blocks reset, flag still set
    step(0, 1, 10, 16'h0001, 0); rd("R9", 10);
    step(0, 1, 0, '0, 0);
    ticks(10);
    chk("R9", {15'b0, rst_req}, '0, "gated reset");
    rd("R9", 6);

    // R11 boot flag
    step(0, 0, 0, '0, 1); rd("R11", 6);
    step(0, 1, 6, 16'h0004, 0); rd("R11", 6);

    // R10 set wins over same-cycle clear
    step(0, 1, 4, 16'h0008, 0);
    step(0, 1, 0, '0, 0);
    ticks(4);
    step(1, 1, 4, 16'h0008, 0); rd("R10", 4);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 19);
      logic [DW-1:0] d = DW'($urandom);
      int a = 2 * $urandom_range(0, 5);
      if (a == 8) d[11] = ($urandom_range(0, 3) == 0);
      if (a == 2 && $urandom_range(0, 1) == 1) d[CW-1:0] = CW'($urandom_range(0, 7));
      if (op < 14)       step(1, 0, 0, '0, 0);
      else if (op < 18)  step($urandom_range(0, 1) == 1, 1, a, d, 0);
      else if (op == 18) step(0, 0, 0, '0, 1);
      else               step(0, 0, 0, '0, 0);
      rd("R4", $urandom_range(0, 11));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule